// File: doc/BRIEF.md
# Pointer and Effective-Address Unit

This unit sits beside a small processor's register file. It works out the 16-bit memory address for a load, store or stack access. It also computes the new values of the two pointer registers, the general pointer pair and the stack pointer, after that access. One operation code chooses the addressing form:

- access through the pointer pair, with optional post-increment or post-decrement;
- access to the top page of the address space, offset by an immediate byte or by a byte register;
- access at an absolute 16-bit address;
- stack push and pop;
- the 16-bit pointer arithmetic that goes with these accesses.

The memory address and its valid flag depend only on the current inputs and are ready in the same cycle. The new pointer values, their write strobes and the carry are registered. They are captured on the rising clock edge when the enable is high. When the enable is low, nothing changes and both strobes read zero.

Signed-offset stack arithmetic produces a carry. The carry is set when the true sum of the unsigned stack pointer and the sign-extended byte falls outside 0..65535. A pair-to-pointer add produces a carry when its 17-bit sum exceeds 0xFFFF. Plain 16-bit increments and decrements pass the incoming carry through unchanged. The data path to memory and the register storage itself are outside this block.

Top module: `agu_sp_unit`

## Requirements
- R1: Operation code 1 addresses 0xFF00 plus the immediate byte. Operation code 2 addresses 0xFF00 plus the byte register input. Both flag the address valid.
- R2: Operation code 0 addresses the current pointer pair. Operation code 3 addresses the 16-bit immediate. Neither writes a pointer.
- R3: Operation codes 4 and 5 address the current pointer pair. They then write the pair as its value plus one (code 4) or minus one (code 5), modulo 65536.
- R4: Operation code 6 (push) writes the stack pointer as its value minus two, modulo 65536, and addresses that new value.
- R5: Operation code 7 (pop) addresses the current stack pointer and writes the stack pointer as its value plus two, modulo 65536.
- R6: Operation code 8 writes the stack pointer as the stack pointer plus the sign-extended immediate byte, masked to 16 bits. Carry is 1 exactly when the unmasked sum is above 0xFFFF or below 0. The pointer pair is not written.
- R7: Operation code 9 writes the pointer pair with the same sum and carry rule as R6. It leaves the stack pointer unchanged and its strobe low.
- R8: Operation code 10 writes the pointer pair as itself plus the 16-bit immediate, masked to 16 bits. Carry is 1 exactly when the 17-bit sum exceeds 0xFFFF.
- R9: Operation codes 11 and 12 increment and decrement the pointer pair. Codes 13 and 14 increment and decrement the stack pointer. All four wrap modulo 65536, and the registered carry equals the carry input.
- R10: Operation code 15 copies the pointer pair into the stack pointer, with the carry passed through.
- R11: With the enable low, the registered pointers and carry hold their values and both write strobes are 0. After reset they are all 0.
- R12: The address-valid output is 1 for operation codes 0 to 7 and 0 for codes 8 to 15. A registered output that an operation does not write equals that register's input, or the carry input for the carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Commit the computed pointers and carry on this edge |
| op_i | input | 4 | Operation code |
| hl_i | input | 16 | Current pointer pair |
| sp_i | input | 16 | Current stack pointer |
| c_i | input | 8 | Byte register used for top-page offset |
| imm8_i | input | 8 | Immediate byte (page offset or signed offset) |
| imm16_i | input | 16 | Absolute address or pair operand |
| cy_i | input | 1 | Incoming carry |
| mem_addr_o | output | 16 | Effective memory address (same cycle) |
| addr_vld_o | output | 1 | Operation performs a memory access |
| hl_q_o | output | 16 | Registered next pointer pair |
| sp_q_o | output | 16 | Registered next stack pointer |
| cy_q_o | output | 1 | Registered carry |
| hl_wr_o | output | 1 | Registered write strobe for the pointer pair |
| sp_wr_o | output | 1 | Registered write strobe for the stack pointer |

## Verification
Address errors appear at once on the combinational address port, in the same cycle the operation is driven. Pointer and carry errors appear one clock after the committing edge.

The push and pop address paths are built separately from the stack-pointer arithmetic. A mismatch between them shows as a registered stack pointer that disagrees with the previous cycle's address. Offset carries are checked against every byte value at pointers near zero, near 0x8000 and near 0xFFFF, so a lost sign extension or a bad carry boundary shows within the sweep of that operation.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [3:0] {
    OP_AT_HL      = 4'd0,
    OP_HI_IMM     = 4'd1,
    OP_HI_C       = 4'd2,
    OP_ABS        = 4'd3,
    OP_HL_POSTINC = 4'd4,
    OP_HL_POSTDEC = 4'd5,
    OP_PUSH       = 4'd6,
    OP_POP        = 4'd7,
    OP_SP_OFS     = 4'd8,
    OP_HL_SPOFS   = 4'd9,
    OP_HL_ADD     = 4'd10,
    OP_HL_INC     = 4'd11,
    OP_HL_DEC     = 4'd12,
    OP_SP_INC     = 4'd13,
    OP_SP_DEC     = 4'd14,
    OP_SP_FROM_HL = 4'd15
  } agu_op_e;

  function automatic logic is_mem_op(agu_op_e op);
    return (op inside {OP_AT_HL, OP_HI_IMM, OP_HI_C, OP_ABS,
                       OP_HL_POSTINC, OP_HL_POSTDEC, OP_PUSH, OP_POP});
  endfunction

  function automatic logic keeps_carry(agu_op_e op);
    return (op inside {OP_HL_INC, OP_HL_DEC, OP_SP_INC, OP_SP_DEC,
                       OP_SP_FROM_HL, OP_HL_POSTINC, OP_HL_POSTDEC});
  endfunction
endpackage

// File: rtl/agu_addr_gen.sv
module agu_addr_gen
  import agu_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int OFS_W = 8
) (
  input  agu_op_e          op,
  input  logic [PTR_W-1:0] hl,
  input  logic [PTR_W-1:0] sp,
  input  logic [OFS_W-1:0] c_reg,
  input  logic [OFS_W-1:0] imm8,
  input  logic [PTR_W-1:0] imm16,
  output logic [PTR_W-1:0] addr,
  output logic             vld
);
  localparam logic [PTR_W-1:0] PAGE_BASE = {{(PTR_W-OFS_W){1'b1}}, {OFS_W{1'b0}}};
  localparam logic [PTR_W-1:0] STACK_STEP = PTR_W'(2);

  function automatic logic [PTR_W-1:0] page_addr(logic [OFS_W-1:0] low);
    return PAGE_BASE | {{(PTR_W-OFS_W){1'b0}}, low};
  endfunction

  // push address is formed here on its own, independent of the pointer unit
  function automatic logic [PTR_W-1:0] pre_push(logic [PTR_W-1:0] s);
    return s + ~STACK_STEP + PTR_W'(1);
  endfunction

  always_comb begin
    vld = is_mem_op(op);
    unique case (op)
      OP_HI_IMM: addr = page_addr(imm8);
      OP_HI_C:   addr = page_addr(c_reg);
      OP_ABS:    addr = imm16;
      OP_PUSH:   addr = pre_push(sp);
      OP_POP:    addr = sp;
      OP_AT_HL, OP_HL_POSTINC, OP_HL_POSTDEC: addr = hl;
      default:   addr = '0;
    endcase
  end
endmodule

// File: rtl/agu_ptr_calc.sv
module agu_ptr_calc
  import agu_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int OFS_W = 8
) (
  input  agu_op_e          op,
  input  logic [PTR_W-1:0] hl,
  input  logic [PTR_W-1:0] sp,
  input  logic [OFS_W-1:0] imm8,
  input  logic [PTR_W-1:0] imm16,
  input  logic             cy_in,
  output logic [PTR_W-1:0] hl_nxt,
  output logic [PTR_W-1:0] sp_nxt,
  output logic             cy_nxt,
  output logic             hl_we,
  output logic             sp_we
);
  localparam int XW = PTR_W + 2;

  // sign-extended offset add; returns {carry, sum}
  function automatic logic [PTR_W:0] offset_add(logic [PTR_W-1:0] base,
                                                logic [OFS_W-1:0] off);
    logic [XW-1:0] t;
    t = {2'b00, base} + {{(XW-OFS_W){off[OFS_W-1]}}, off};
    return {t[XW-1] | t[XW-2], t[PTR_W-1:0]};
  endfunction

  function automatic logic [PTR_W:0] pair_add(logic [PTR_W-1:0] a,
                                              logic [PTR_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] v, logic up, int amt);
    return up ? v + PTR_W'(amt) : v - PTR_W'(amt);
  endfunction

  logic [PTR_W:0] ofs_res;
  logic [PTR_W:0] add_res;

  assign ofs_res = offset_add(sp, imm8);
  assign add_res = pair_add(hl, imm16);

  always_comb begin
    hl_nxt = hl;
    sp_nxt = sp;
    cy_nxt = cy_in;
    hl_we  = 1'b0;
    sp_we  = 1'b0;
    unique case (op)
      OP_HL_POSTINC, OP_HL_INC: begin hl_nxt = step(hl, 1'b1, 1); hl_we = 1'b1; end
      OP_HL_POSTDEC, OP_HL_DEC: begin hl_nxt = step(hl, 1'b0, 1); hl_we = 1'b1; end
      OP_PUSH:   begin sp_nxt = step(sp, 1'b0, 2); sp_we = 1'b1; end
      OP_POP:    begin sp_nxt = step(sp, 1'b1, 2); sp_we = 1'b1; end
      OP_SP_INC: begin sp_nxt = step(sp, 1'b1, 1); sp_we = 1'b1; end
      OP_SP_DEC: begin sp_nxt = step(sp, 1'b0, 1); sp_we = 1'b1; end
      OP_SP_OFS: begin
        sp_nxt = ofs_res[PTR_W-1:0]; cy_nxt = ofs_res[PTR_W]; sp_we = 1'b1;
      end
      OP_HL_SPOFS: begin
        hl_nxt = ofs_res[PTR_W-1:0]; cy_nxt = ofs_res[PTR_W]; hl_we = 1'b1;
      end
      OP_HL_ADD: begin
        hl_nxt = add_res[PTR_W-1:0]; cy_nxt = add_res[PTR_W]; hl_we = 1'b1;
      end
      OP_SP_FROM_HL: begin sp_nxt = hl; sp_we = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/agu_commit.sv
module agu_commit #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PTR_W-1:0] hl_nxt,
  input  logic [PTR_W-1:0] sp_nxt,
  input  logic             cy_nxt,
  input  logic             hl_we,
  input  logic             sp_we,
  output logic [PTR_W-1:0] hl_q,
  output logic [PTR_W-1:0] sp_q,
  output logic             cy_q,
  output logic             hl_wr,
  output logic             sp_wr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hl_q  <= '0;
      sp_q  <= '0;
      cy_q  <= 1'b0;
      hl_wr <= 1'b0;
      sp_wr <= 1'b0;
    end else begin
      hl_wr <= en & hl_we;
      sp_wr <= en & sp_we;
      if (en) begin
        hl_q <= hl_nxt;
        sp_q <= sp_nxt;
        cy_q <= cy_nxt;
      end
    end
  end
endmodule

// File: rtl/agu_sp_unit.sv
module agu_sp_unit
  import agu_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [3:0]       op_i,
  input  logic [PTR_W-1:0] hl_i,
  input  logic [PTR_W-1:0] sp_i,
  input  logic [OFS_W-1:0] c_i,
  input  logic [OFS_W-1:0] imm8_i,
  input  logic [PTR_W-1:0] imm16_i,
  input  logic             cy_i,
  output logic [PTR_W-1:0] mem_addr_o,
  output logic             addr_vld_o,
  output logic [PTR_W-1:0] hl_q_o,
  output logic [PTR_W-1:0] sp_q_o,
  output logic             cy_q_o,
  output logic             hl_wr_o,
  output logic             sp_wr_o
);
  agu_op_e          op;
  logic [PTR_W-1:0] hl_nxt, sp_nxt;
  logic             cy_nxt, hl_we, sp_we;

  assign op = agu_op_e'(op_i);

  agu_addr_gen #(.PTR_W(PTR_W), .OFS_W(OFS_W)) u_addr (
    .op(op), .hl(hl_i), .sp(sp_i), .c_reg(c_i), .imm8(imm8_i), .imm16(imm16_i),
    .addr(mem_addr_o), .vld(addr_vld_o)
  );

  agu_ptr_calc #(.PTR_W(PTR_W), .OFS_W(OFS_W)) u_ptr (
    .op(op), .hl(hl_i), .sp(sp_i), .imm8(imm8_i), .imm16(imm16_i), .cy_in(cy_i),
    .hl_nxt(hl_nxt), .sp_nxt(sp_nxt), .cy_nxt(cy_nxt), .hl_we(hl_we), .sp_we(sp_we)
  );

  agu_commit #(.PTR_W(PTR_W)) u_commit (
    .clk(clk), .rst(rst), .en(en_i),
    .hl_nxt(hl_nxt), .sp_nxt(sp_nxt), .cy_nxt(cy_nxt), .hl_we(hl_we), .sp_we(sp_we),
    .hl_q(hl_q_o), .sp_q(sp_q_o), .cy_q(cy_q_o), .hl_wr(hl_wr_o), .sp_wr(sp_wr_o)
  );

  AST_HIGH_PAGE_IMM: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HI_IMM) |-> (&mem_addr_o[PTR_W-1:OFS_W]) && addr_vld_o
                          && (mem_addr_o[OFS_W-1:0] == imm8_i)); // R1
  AST_POSTINC_FROM_ADDR: assert property (@(posedge clk) disable iff (rst)
    (en_i && op == OP_HL_POSTINC) |=>
      hl_q_o == PTR_W'($past(mem_addr_o) + PTR_W'(1))); // R3
  AST_PUSH_ADDR_IS_NEW_SP: assert property (@(posedge clk) disable iff (rst)
    (en_i && op == OP_PUSH) |=> sp_wr_o && (sp_q_o == $past(mem_addr_o))); // R4
  AST_POP_STEP_FROM_ADDR: assert property (@(posedge clk) disable iff (rst)
    (en_i && op == OP_POP) |=>
      sp_q_o == PTR_W'($past(mem_addr_o) + PTR_W'(2))); // R5
  AST_SPOFS_KEEPS_SP: assert property (@(posedge clk) disable iff (rst)
    (en_i && op == OP_HL_SPOFS) |=> hl_wr_o && !sp_wr_o); // R7
  AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (en_i && op inside {OP_HL_INC, OP_HL_DEC, OP_SP_INC, OP_SP_DEC}) |=>
      cy_q_o == $past(cy_i)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(hl_q_o) && $stable(sp_q_o) && $stable(cy_q_o)
              && !hl_wr_o && !sp_wr_o); // R11
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hl_wr_o, sp_wr_o})); // R12
endmodule

// File: tb/agu_sp_unit_tb.sv
module agu_sp_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [15:0] hl_i = '0, sp_i = '0, imm16_i = '0;
  logic [7:0]  c_i = '0, imm8_i = '0;
  logic        cy_i = 1'b0;
  logic [15:0] mem_addr_o, hl_q_o, sp_q_o;
  logic        addr_vld_o, cy_q_o, hl_wr_o, sp_wr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  agu_sp_unit u_dut (
    .clk(clk), .rst(rst), .en_i(en_i), .op_i(op_i), .hl_i(hl_i), .sp_i(sp_i),
    .c_i(c_i), .imm8_i(imm8_i), .imm16_i(imm16_i), .cy_i(cy_i),
    .mem_addr_o(mem_addr_o), .addr_vld_o(addr_vld_o), .hl_q_o(hl_q_o),
    .sp_q_o(sp_q_o), .cy_q_o(cy_q_o), .hl_wr_o(hl_wr_o), .sp_wr_o(sp_wr_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(int op);
    case (op)
      0, 3: return "R2";
      1, 2: return "R1";
      4, 5: return "R3";
      6: return "R4";
      7: return "R5";
      8: return "R6";
      9: return "R7";
      10: return "R8";
      15: return "R10";
      default: return "R9";
    endcase
  endfunction

  function automatic int corner(int k);
    case (k % 8)
      0: return 'h0000; 1: return 'h0001; 2: return 'hFFFF; 3: return 'hFFFE;
      4: return 'h8000; 5: return 'h7FFF; 6: return 'hFF80; default: return 'h0080;
    endcase
  endfunction

  task automatic apply(int op, int hl, int sp, int c, int i8, int i16, int cy);
    int e_addr, e_vld, e_hl, e_sp, e_cy, e_hw, e_sw, s, sum;
    string t;
    t = tag_of(op);
    e_hl = hl; e_sp = sp; e_cy = cy; e_hw = 0; e_sw = 0; e_addr = 0;
    e_vld = (op < 8) ? 1 : 0;
    s = (i8 >= 128) ? i8 - 256 : i8;
    case (op)
      0: e_addr = hl;
      1: e_addr = 'hFF00 + i8;
      2: e_addr = 'hFF00 + c;
      3: e_addr = i16;
      4: begin e_addr = hl; e_hl = (hl + 1) & 'hFFFF; e_hw = 1; end
      5: begin e_addr = hl; e_hl = (hl + 'hFFFF) & 'hFFFF; e_hw = 1; end
      6: begin e_sp = (sp + 'hFFFE) & 'hFFFF; e_addr = e_sp; e_sw = 1; end
      7: begin e_addr = sp; e_sp = (sp + 2) & 'hFFFF; e_sw = 1; end
      8: begin sum = sp + s; e_cy = (sum > 'hFFFF || sum < 0) ? 1 : 0;
               e_sp = sum & 'hFFFF; e_sw = 1; end
      9: begin sum = sp + s; e_cy = (sum > 'hFFFF || sum < 0) ? 1 : 0;
               e_hl = sum & 'hFFFF; e_hw = 1; end
      10: begin sum = hl + i16; e_cy = (sum > 'hFFFF) ? 1 : 0;
                e_hl = sum & 'hFFFF; e_hw = 1; end
      11: begin e_hl = (hl + 1) & 'hFFFF; e_hw = 1; end
      12: begin e_hl = (hl + 'hFFFF) & 'hFFFF; e_hw = 1; end
      13: begin e_sp = (sp + 1) & 'hFFFF; e_sw = 1; end
      14: begin e_sp = (sp + 'hFFFF) & 'hFFFF; e_sw = 1; end
      default: begin e_sp = hl; e_sw = 1; end
    endcase
    @(negedge clk);
    en_i = 1'b1; op_i = 4'(op); hl_i = 16'(hl); sp_i = 16'(sp);
    c_i = 8'(c); imm8_i = 8'(i8); imm16_i = 16'(i16); cy_i = cy[0];
    #2;
    chk("R12", "addr valid", int'(addr_vld_o), e_vld);
    if (e_vld == 1) chk(t, "address", int'(mem_addr_o), e_addr);
    @(posedge clk);
    #2;
    chk(t, "next hl", int'(hl_q_o), e_hl);
    chk(t, "next sp", int'(sp_q_o), e_sp);
    chk(t, "carry", int'(cy_q_o), e_cy);
    chk(t, "hl strobe", int'(hl_wr_o), e_hw);
    chk(t, "sp strobe", int'(sp_wr_o), e_sw);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
    // R11: reset state
    chk("R11", "reset hl", int'(hl_q_o), 0);
    chk("R11", "reset sp", int'(sp_q_o), 0);
    chk("R11", "reset carry", int'(cy_q_o), 0);
    chk("R11", "reset strobes", int'({hl_wr_o, sp_wr_o}), 0);

    for (int op = 0; op < 16; op++)
      for (int k = 0; k < 8; k++)
        for (int m = 0; m < 256; m++)
          apply(op, corner(k), corner(k + 3), m ^ 'h5A, m,
                (m * 257 + corner(k + 5)) & 'hFFFF, m & 1);

    // R11: enable low after a known commit holds everything
    apply(8, 'h1234, 'h0005, 0, 'hF0, 0, 0);
    @(negedge clk);
    en_i = 1'b0; op_i = 4'd10; hl_i = 16'hFFFF; sp_i = 16'hAAAA;
    imm16_i = 16'hFFFF; cy_i = 1'b1;
    @(posedge clk);
    #2;
    chk("R11", "idle hl", int'(hl_q_o), 'h1234);
    chk("R11", "idle sp", int'(sp_q_o), 'hFFF5);
    chk("R11", "idle carry", int'(cy_q_o), 1);
    chk("R11", "idle strobes", int'({hl_wr_o, sp_wr_o}), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule